// File: doc/BRIEF.md
# Alternating-Register Output Decorrelator

This block post-processes the bit stream of any bit-serial generator. Each accepted input bit goes to one of two 16-bit history shift registers, and the target flips on every accepted bit. Only the target register shifts; the other one holds. The output bit is the parity of four fixed taps of the register that was just stepped. The bits that reach the output therefore come from a pattern that depends on how the stream has been split so far, not from a fixed window of past bits. A fixed window could be inverted by simple deconvolution.

A mode input selects a recycling variant. In that mode, a per-bit control input chosen alongside the data bit decides whether the stepped register takes the new bit or puts back its own outgoing bit. In this mode the output also mixes in one bit of the register that was not stepped. The output is registered and qualified by a valid flag. That flag stays low until both history registers have been fully loaded.

Top module: `alt_decorrelator`

## Requirements
- R1: While reset is held and after its release, out_valid_o and out_bit_o are 0, both history registers are all zero, and the first accepted bit goes to register A.
- R2: Every cycle with valid_i high moves the target to the other register (A, B, A, ...). Cycles with valid_i low leave the target unchanged.
- R3: On an accepted bit, only the target register shifts. The other register keeps its contents.
- R4: A shift moves every bit one place up (bit 0 is the newest). The output bit is the XOR of bits 0, 3, 7 and 12 of the target register after the shift.
- R5: out_valid_o is high only in the cycle right after a cycle with valid_i high.
- R6: out_valid_o stays low until each register has taken 16 bits. With no reset in between, the first high out_valid_o follows the 32nd accepted bit.
- R7: With mode_i = 1 and recyc_i = 1, the target register puts its old bit 15 into bit 0 in place of bit_i.
- R8: With mode_i = 1, the output bit is also XORed with bit 5 of the register that was not stepped.
- R9: With mode_i = 0, recyc_i has no effect on the registers or on the output.
- R10: out_bit_o holds its value through cycles in which valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Incoming generator bit |
| valid_i | input | 1 | bit_i and recyc_i are accepted this cycle |
| mode_i | input | 1 | 0: plain alternation; 1: recycling variant |
| recyc_i | input | 1 | In recycling mode, reinsert the outgoing bit instead of bit_i |
| out_bit_o | output | 1 | Decorrelated output bit |
| out_valid_o | output | 1 | out_bit_o is valid |

## Verification
The bench uses the default 16-bit registers, taps 0/3/7/12 and mix tap 5. At these values the fill gate opens after 32 bits, so it can be reached within a few hundred cycles, and the oldest bit that recycling reinserts cycles back into the taps quickly. The bench streams random data and switches between the two modes. It also leaves idle gaps of random length, which exercise the rule that only accepted bits flip the target. Every clock it compares the outputs with a queue-based model.

// File: rtl/decor_pkg.sv
package decor_pkg;
  typedef enum logic {SEL_A = 1'b0, SEL_B = 1'b1} sel_e;

  localparam int unsigned NUM_REGS = 2;

  function automatic logic [31:0] tap_mask4(input int unsigned t0, input int unsigned t1,
                                            input int unsigned t2, input int unsigned t3);
    logic [31:0] m;
    m = '0;
    m[t0] = 1'b1;
    m[t1] = 1'b1;
    m[t2] = 1'b1;
    m[t3] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/decor_hist_reg.sv
module decor_hist_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         recyc_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nx_o
);
  logic [W-1:0] q_q;
  logic         ins;

  // recycle puts the outgoing bit back in at the bottom
  assign ins  = recyc_i ? q_q[W-1] : bit_i;
  assign nx_o = shift_i ? {q_q[W-2:0], ins} : q_q;
  assign q_o  = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nx_o;
  end
endmodule

// File: rtl/decor_fill_cnt.sv
module decor_fill_cnt #(
  parameter int unsigned W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic full_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d  = (inc_i && cnt_q != FULL) ? cnt_q + 1'b1 : cnt_q;
  // full including the bit taken this cycle
  assign full_o = (cnt_d == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/decor_tap_xor.sv
module decor_tap_xor #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  MASK = '0
) (
  input  logic [W-1:0] vec_i,
  output logic         par_o
);
  assign par_o = ^(vec_i & MASK);
endmodule

// File: rtl/alt_decorrelator.sv
module alt_decorrelator #(
  parameter int unsigned W       = 16,
  parameter int unsigned TAP0    = 0,
  parameter int unsigned TAP1    = 3,
  parameter int unsigned TAP2    = 7,
  parameter int unsigned TAP3    = 12,
  parameter int unsigned MIX_TAP = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic valid_i,
  input  logic mode_i,
  input  logic recyc_i,
  output logic out_bit_o,
  output logic out_valid_o
);
  import decor_pkg::*;

  localparam logic [31:0]  MASK32   = tap_mask4(TAP0, TAP1, TAP2, TAP3);
  localparam logic [W-1:0] TAP_MASK = MASK32[W-1:0];
  localparam logic [W-1:0] MIX_MASK = W'(1) << MIX_TAP;

  sel_e         sel_q;
  logic [W-1:0] hist_q  [NUM_REGS];
  logic [W-1:0] hist_nx [NUM_REGS];
  logic         full    [NUM_REGS];
  logic [W-1:0] tgt_nx;
  logic [W-1:0] oth_q;
  logic         tap_par;
  logic         mix_par;
  logic         recyc_en;

  assign recyc_en = mode_i & recyc_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic step;
    assign step = valid_i && (sel_q == sel_e'(g));

    decor_hist_reg #(.W(W)) u_hist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(step),
      .recyc_i(recyc_en),
      .bit_i  (bit_i),
      .q_o    (hist_q[g]),
      .nx_o   (hist_nx[g])
    );

    decor_fill_cnt #(.W(W)) u_fill (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (step),
      .full_o(full[g])
    );
  end

  assign tgt_nx = (sel_q == SEL_B) ? hist_nx[1] : hist_nx[0];
  assign oth_q  = (sel_q == SEL_B) ? hist_q[0]  : hist_q[1];

  decor_tap_xor #(.W(W), .MASK(TAP_MASK)) u_tap (
    .vec_i(tgt_nx),
    .par_o(tap_par)
  );

  decor_tap_xor #(.W(W), .MASK(MIX_MASK)) u_mix (
    .vec_i(oth_q),
    .par_o(mix_par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= SEL_A;
      out_bit_o   <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= valid_i && full[0] && full[1];
      if (valid_i) begin
        sel_q     <= (sel_q == SEL_A) ? SEL_B : SEL_A;
        out_bit_o <= tap_par ^ (mode_i & mix_par);
      end
    end
  end
endmodule

// File: rtl/alt_decorrelator_chk.sv
module alt_decorrelator_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         out_bit_o,
  input logic         out_valid_o,
  input logic         sel_q,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b
);
  localparam int unsigned LIM = 2 * W;
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            acc_q <= '0;
    else if (valid_i && acc_q != CW'(LIM))  acc_q <= acc_q + 1'b1;
  end

  AST_VALID_FOLLOWS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !out_valid_o) else $error("AST_VALID_FOLLOWS_IN"); // R5
  AST_FILL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> acc_q == CW'(LIM)) else $error("AST_FILL_GATE"); // R6
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(out_bit_o)) else $error("AST_BIT_HOLD"); // R10
  AST_SEL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> sel_q != $past(sel_q)) else $error("AST_SEL_FLIP"); // R2
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sel_q)) else $error("AST_SEL_IDLE"); // R2
  AST_B_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sel_q) |=> $stable(reg_b)) else $error("AST_B_HOLDS"); // R3
  AST_A_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_q) |=> $stable(reg_a)) else $error("AST_A_HOLDS"); // R3
endmodule

bind alt_decorrelator alt_decorrelator_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .out_bit_o  (out_bit_o),
  .out_valid_o(out_valid_o),
  .sel_q      (sel_q),
  .reg_a      (hist_q[0]),
  .reg_b      (hist_q[1])
);

// File: tb/alt_decorrelator_bench.sv
module alt_decorrelator_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0, valid_in = 1'b0, mode_in = 1'b0, recyc_in = 1'b0;
  logic out_bit, out_valid;

  int n_chk = 0, n_fail = 0;
  bit hq0[$], hq1[$];
  int cnt0 = 0, cnt1 = 0, n_acc = 0, first_valid = -1;
  bit sel = 0, exp_bit = 0, exp_val = 0;

  always #4 clk = ~clk;

  alt_decorrelator u_alt_decorrelator (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .valid_i(valid_in),
    .mode_i(mode_in), .recyc_i(recyc_in), .out_bit_o(out_bit), .out_valid_o(out_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference: queue front = newest bit (position 0)
  task automatic model(input bit v, input bit b, input bit m, input bit r);
    bit ins;
    bit t[$];
    bit o[$];
    if (!v) begin
      exp_val = 0;
      return;
    end
    n_acc++;
    if (sel == 0) begin
      ins = (m && r) ? hq0[15] : b;
      hq0.push_front(ins); void'(hq0.pop_back());
      cnt0++; t = hq0; o = hq1;
    end else begin
      ins = (m && r) ? hq1[15] : b;
      hq1.push_front(ins); void'(hq1.pop_back());
      cnt1++; t = hq1; o = hq0;
    end
    exp_bit = t[0] ^ t[3] ^ t[7] ^ t[12] ^ (m & o[5]);
    exp_val = (cnt0 >= 16) && (cnt1 >= 16);
    sel = ~sel;
  endtask

  task automatic step(input bit v, input bit b, input bit m, input bit r);
    bit prev_bit;
    prev_bit = out_bit;
    bit_in = b; valid_in = v; mode_in = m; recyc_in = r;
    model(v, b, m, r);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == exp_val, "R5 R6 out_valid", out_valid, exp_val);
    if (out_valid && first_valid < 0) begin
      first_valid = n_acc;
      check(n_acc == 32, "R6 first valid index", n_acc, 32);
    end
    if (!v)
      check(out_bit == prev_bit, "R10 hold on idle", out_bit, prev_bit);
    else if (m)
      check(out_bit == exp_bit, "R2 R3 R7 R8 recycle-mode bit", out_bit, exp_bit);
    else if (r)
      check(out_bit == exp_bit, "R9 recyc ignored in plain mode", out_bit, exp_bit);
    else
      check(out_bit == exp_bit, "R2 R3 R4 plain bit", out_bit, exp_bit);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin hq0.push_back(0); hq1.push_back(0); end
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    check(out_bit == 0, "R1 reset bit", out_bit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_bit == 0, "R1 after release", {out_valid, out_bit}, 0);
    // R1: first bit to A; single 1 into A gives bit0 tap -> 1
    step(1, 1, 0, 0);
    check(out_bit == 1, "R1 R4 first bit into A", out_bit, 1);
    // fill phase with idle gaps, plain mode, random recyc (R9)
    for (int i = 0; i < 60; i++) begin
      step(1, 1'($urandom), 0, 1'($urandom));
      if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) step(0, 1'($urandom), 0, 1'($urandom));
    end
    check(first_valid == 32, "R6 gate opened at 32", first_valid, 32);
    // recycling mode
    for (int i = 0; i < 200; i++) begin
      step(1, 1'($urandom), 1, 1'($urandom));
      if ($urandom % 5 == 0) step(0, 1'($urandom), 1, 1'($urandom));
    end
    // pure recycle: registers rotate, no input used
    for (int i = 0; i < 64; i++) step(1, 1'($urandom), 1, 1);
    // back to plain, R9 with recyc held high
    for (int i = 0; i < 100; i++) step(1, 1'($urandom), 0, 1);
    for (int i = 0; i < 100; i++) step($urandom % 3 != 0, 1'($urandom), 1'($urandom), 1'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule